// File: doc/BRIEF.md
# Direct-Mapped FIFO and Mailbox Host Interface

This block sits between a host bus and a local processor. It gives the host a small window of eight byte offsets. Every register in that window is reached in a single access, with no pointer register in between. Data travels through two FIFOs: the outbound FIFO carries host-to-board data and the inbound FIFO carries board-to-host data. Each FIFO entry is 16 bits wide. The `word_mode` input selects word or byte transfers on the host data port. In byte mode only half of the FIFO depth is usable.

Short messages travel through two mailboxes, one in each direction. Each mailbox holds 6 bits. When the local processor consumes the outbound mailbox, its contents stay in place, and only a status flag records that it was taken. The host sees a status byte and writes an interrupt mask. The bits of that mask are laid out differently from the status bits, and the top mask bit chooses which mailbox a host read returns. The host interrupt is the masked OR of the conditions, gated by a global enable. The local processor sets that enable, and any reset clears it. A host write to offset 7 clears the whole block.

Top module: `hbx_host_if`

## Requirements
- R1: After reset the status byte reads 0x21 (inbound empty and outbound empty), `host_irq` is low and a mailbox read at offset 3 returns 0.
- R2: When `word_mode`=0, a byte write at offset 0 pushes {0x00, byte} into the outbound FIFO. The usable capacity is DEPTH/2 entries. Writes made while the FIFO is full are dropped.
- R3: When `word_mode`=1, a word write at offset 0 pushes the whole 16-bit value. A byte write at offset 1 stages an upper byte, and a later byte write at offset 0 pushes {staged, byte}. The usable capacity is DEPTH entries.
- R4: A host read at offset 0 pops one inbound entry. A word read returns all 16 bits. A byte read returns {0x00, low byte} and discards the upper byte. A read while the inbound FIFO is empty returns 0 and pops nothing.
- R5: The status byte read at offset 2 has these bits: 0x80 outbound mailbox unread, 0x40 outbound full, 0x20 inbound empty, 0x10 outbound at least half full, 0x08 inbound at least half full, 0x04 inbound mailbox full, 0x02 inbound full, 0x01 outbound empty. "Half" means half of the current usable capacity.
- R6: A write at offset 2 loads the mask. Each enable bit is paired with one status bit: 0x40 with 0x04, 0x20 with 0x02, 0x08 with 0x20, 0x04 with 0x40, and 0x01 with 0x01. Reserved mask bits 0x10 and 0x02 are stored as zero and never raise the interrupt.
- R7: `host_irq` stays low while the global enable is clear. Reset clears the enable, and a pulse on `loc_irq_arm` sets it.
- R8: Each mailbox stores only bits 7..2, so bits 1..0 of any mailbox value always read 0.
- R9: A host read at offset 3 returns the inbound mailbox when mask bit 0x80 is 0, and that read clears status 0x04. When mask bit 0x80 is 1, the read returns the outbound mailbox and clears nothing. A host write at offset 3 always loads the outbound mailbox.
- R10: A host write to the outbound mailbox sets status 0x80. A local read (`loc_mbox_rd`) clears that flag and keeps the stored value.
- R11: A host write at offset 7 clears both FIFOs, both mailboxes, the mask and the global enable. A host read at offset 7 returns 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_mode | input | 1 | 1 selects 16-bit transfers, 0 selects 8-bit transfers |
| host_addr | input | 3 | Host byte offset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_word | input | 1 | The current access is word-wide |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data |
| host_irq | output | 1 | Masked host interrupt |
| loc_push | input | 1 | Local side pushes an inbound entry |
| loc_push_data | input | 16 | Inbound entry |
| loc_in_full | output | 1 | Inbound FIFO is at capacity |
| loc_pop | input | 1 | Local side pops an outbound entry |
| loc_pop_data | output | 16 | Head of the outbound FIFO |
| loc_out_empty | output | 1 | Outbound FIFO is empty |
| loc_mbox_wr | input | 1 | Local side writes the inbound mailbox |
| loc_mbox_wdata | input | 8 | Inbound mailbox value |
| loc_mbox_rd | input | 1 | Local side consumes the outbound mailbox |
| loc_mbox_rdata | output | 8 | Outbound mailbox value |
| loc_irq_arm | input | 1 | Sets the global interrupt enable |

## Verification
The outbound data port is exercised in three ways:
- Plain byte writes in byte mode, which confirm the zero upper byte and the half-depth limit.
- Word writes in word mode.
- A staged upper byte followed by a byte write in word mode, which tells the two word-mode byte lanes apart.

The inbound path is filled to capacity and then read back with word reads, byte reads and reads while empty. These show that a pop drops the upper byte in byte reads and that nothing is popped once the FIFO is empty. Each mask enable is set on its own while its paired condition is either true or false. This separates the mask layout from the status layout and shows that the reserved bits have no effect. The mailbox sequences switch the readback select between reads, so they tell apart the reads that clear the inbound flag from those that clear nothing.

// File: rtl/hbx_pkg.sv
package hbx_pkg;

  // Host byte offsets.
  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_DHI  = 3'd1;
  localparam logic [2:0] OFS_STAT = 3'd2;
  localparam logic [2:0] OFS_MBOX = 3'd3;
  localparam logic [2:0] OFS_RST  = 3'd7;

  // Mask bit positions. These differ from the status bit positions.
  localparam int MB_RSEL     = 7;
  localparam int MB_INMAIL   = 6;
  localparam int MB_INFULL   = 5;
  localparam int MB_INEMPTY  = 3;
  localparam int MB_OUTFULL  = 2;
  localparam int MB_OUTEMPTY = 0;

  localparam logic [7:0] MASK_KEEP = 8'hED;

  // Status byte, most significant bit first.
  typedef struct packed {
    logic out_mail;
    logic out_full;
    logic in_empty;
    logic out_half;
    logic in_half;
    logic in_mail;
    logic in_full;
    logic out_empty;
  } status_t;

  function automatic logic [7:0] keep_mask(input logic [7:0] m);
    return m & MASK_KEEP;
  endfunction

  function automatic logic irq_hit(input logic [7:0] m, input status_t s);
    return (m[MB_INMAIL]   & s.in_mail)  |
           (m[MB_INFULL]   & s.in_full)  |
           (m[MB_INEMPTY]  & s.in_empty) |
           (m[MB_OUTFULL]  & s.out_full) |
           (m[MB_OUTEMPTY] & s.out_empty);
  endfunction

  function automatic int unsigned usable_cap(input int unsigned depth, input logic wmode);
    return wmode ? depth : depth / 2;
  endfunction

endpackage

// File: rtl/hbx_fifo.sv
module hbx_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [CW-1:0] cap,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count >= cap);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= step(wr_ptr);
      if (pop_ok)  rd_ptr <= step(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !clr) mem[wr_ptr] <= push_data;
  end

endmodule

// File: rtl/hbx_mailbox.sv
module hbx_mailbox #(
  parameter int W    = 8,
  parameter int KEEP = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         take,
  output logic [W-1:0] value,
  output logic         pending
);

  logic [KEEP-1:0] held;

  assign value = {held, {(W-KEEP){1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held    <= '0;
      pending <= 1'b0;
    end else if (clr) begin
      held    <= '0;
      pending <= 1'b0;
    end else begin
      if (load) held <= load_data[W-1 -: KEEP];
      if (load)      pending <= 1'b1;
      else if (take) pending <= 1'b0;
    end
  end

endmodule

// File: rtl/hbx_host_if.sv
module hbx_host_if #(
  parameter int DEPTH   = 16,
  parameter int DW      = 16,
  parameter int MBW     = 8,
  parameter int MB_KEEP = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          word_mode,
  input  logic [2:0]    host_addr,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic          host_word,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          host_irq,
  input  logic          loc_push,
  input  logic [DW-1:0] loc_push_data,
  output logic          loc_in_full,
  input  logic          loc_pop,
  output logic [DW-1:0] loc_pop_data,
  output logic          loc_out_empty,
  input  logic          loc_mbox_wr,
  input  logic [MBW-1:0] loc_mbox_wdata,
  input  logic          loc_mbox_rd,
  output logic [MBW-1:0] loc_mbox_rdata,
  input  logic          loc_irq_arm
);
  import hbx_pkg::*;

  localparam int BW = DW / 2;
  localparam int CW = $clog2(DEPTH + 1);

  // Decoded host events, named so that the checker can observe them.
  logic wr_data, wr_dhi, wr_mask, wr_mbox, soft_rst;
  logic rd_data, rd_mbox;

  assign wr_data  = host_wr && (host_addr == OFS_DATA);
  assign wr_dhi   = host_wr && (host_addr == OFS_DHI);
  assign wr_mask  = host_wr && (host_addr == OFS_STAT);
  assign wr_mbox  = host_wr && (host_addr == OFS_MBOX);
  assign soft_rst = host_wr && (host_addr == OFS_RST);
  assign rd_data  = host_rd && (host_addr == OFS_DATA);
  assign rd_mbox  = host_rd && (host_addr == OFS_MBOX);

  logic [CW-1:0] cap, half;
  assign cap  = CW'(usable_cap(DEPTH, word_mode));
  assign half = cap >> 1;

  // Host-side registers.
  logic [BW-1:0] hi_stage;
  logic [7:0]    mask_q;
  logic          irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_stage <= '0;
      mask_q   <= '0;
      irq_en   <= 1'b0;
    end else if (soft_rst) begin
      hi_stage <= '0;
      mask_q   <= '0;
      irq_en   <= 1'b0;
    end else begin
      if (wr_dhi)      hi_stage <= host_wdata[BW-1:0];
      if (wr_mask)     mask_q   <= keep_mask(host_wdata[7:0]);
      if (loc_irq_arm) irq_en   <= 1'b1;
    end
  end

  // Outbound path: the host pushes, the local side pops.
  logic [DW-1:0] out_push_data;
  logic [CW-1:0] out_count;
  logic          out_empty, out_full;

  always_comb begin
    if (host_word)      out_push_data = host_wdata;
    else if (word_mode) out_push_data = {hi_stage, host_wdata[BW-1:0]};
    else                out_push_data = {{(DW-BW){1'b0}}, host_wdata[BW-1:0]};
  end

  hbx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_out_fifo (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .cap(cap),
    .push(wr_data), .push_data(out_push_data),
    .pop(loc_pop), .head(loc_pop_data),
    .count(out_count), .empty(out_empty), .full(out_full)
  );

  // Inbound path: the local side pushes, the host pops.
  logic [DW-1:0] in_head;
  logic [CW-1:0] in_count;
  logic          in_empty, in_full;

  hbx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_in_fifo (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .cap(cap),
    .push(loc_push), .push_data(loc_push_data),
    .pop(rd_data), .head(in_head),
    .count(in_count), .empty(in_empty), .full(in_full)
  );

  // Mailboxes.
  logic [MBW-1:0] in_mb_val, out_mb_val;
  logic           in_mb_pend, out_mb_pend, in_mb_take;

  assign in_mb_take = rd_mbox && !mask_q[MB_RSEL];

  hbx_mailbox #(.W(MBW), .KEEP(MB_KEEP)) u_in_mbox (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst),
    .load(loc_mbox_wr), .load_data(loc_mbox_wdata),
    .take(in_mb_take), .value(in_mb_val), .pending(in_mb_pend)
  );

  hbx_mailbox #(.W(MBW), .KEEP(MB_KEEP)) u_out_mbox (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst),
    .load(wr_mbox), .load_data(host_wdata[MBW-1:0]),
    .take(loc_mbox_rd), .value(out_mb_val), .pending(out_mb_pend)
  );

  // Status byte and interrupt.
  status_t    stat;
  logic [7:0] stat_byte;

  always_comb begin
    stat.out_mail  = out_mb_pend;
    stat.out_full  = out_full;
    stat.in_empty  = in_empty;
    stat.out_half  = (out_count >= half);
    stat.in_half   = (in_count >= half);
    stat.in_mail   = in_mb_pend;
    stat.in_full   = in_full;
    stat.out_empty = out_empty;
  end
  assign stat_byte = stat;

  assign host_irq = irq_en && irq_hit(mask_q, stat);

  // Host read mux.
  always_comb begin
    host_rdata = '0;
    if (host_rd) begin
      case (host_addr)
        OFS_DATA: host_rdata = host_word ? in_head : {{(DW-BW){1'b0}}, in_head[BW-1:0]};
        OFS_STAT: host_rdata = DW'(stat_byte);
        OFS_MBOX: host_rdata = mask_q[MB_RSEL] ? DW'(out_mb_val) : DW'(in_mb_val);
        default:  host_rdata = '0;
      endcase
    end
  end

  assign loc_in_full    = in_full;
  assign loc_out_empty  = out_empty;
  assign loc_mbox_rdata = out_mb_val;

endmodule

// File: rtl/hbx_host_if_chk.sv
module hbx_host_if_chk #(
  parameter int DEPTH = 16,
  parameter int DW    = 16,
  parameter int MBW   = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           host_rd,
  input logic [2:0]     host_addr,
  input logic [DW-1:0]  host_rdata,
  input logic           host_irq,
  input logic           irq_en,
  input logic [CW-1:0]  out_count,
  input logic [CW-1:0]  cap,
  input logic           soft_rst,
  input logic           wr_mbox,
  input logic [7:0]     stat_byte,
  input logic           loc_mbox_rd,
  input logic [MBW-1:0] loc_mbox_rdata
);

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !host_irq);  // R7

  AST_OUT_WITHIN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    out_count <= cap);  // R2

  AST_MBOX_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == 3'd3) |-> (host_rdata[1:0] == 2'b00));  // R8

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == 3'd0 && stat_byte[5]) |-> (host_rdata == '0));  // R4

  AST_SOFT_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (stat_byte == 8'h21 && !host_irq && !irq_en));  // R11

  AST_OUTMAIL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_mbox_rd && !wr_mbox && !soft_rst) |=> (!stat_byte[7] && $stable(loc_mbox_rdata)));  // R10

endmodule

bind hbx_host_if hbx_host_if_chk #(.DEPTH(DEPTH), .DW(DW), .MBW(MBW)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_addr(host_addr),
  .host_rdata(host_rdata), .host_irq(host_irq), .irq_en(irq_en),
  .out_count(out_count), .cap(cap), .soft_rst(soft_rst), .wr_mbox(wr_mbox),
  .stat_byte(stat_byte), .loc_mbox_rd(loc_mbox_rd), .loc_mbox_rdata(loc_mbox_rdata)
);

// File: tb/hbx_host_if_test.sv
module hbx_host_if_test;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_mode = 1'b0;
  logic [2:0]  host_addr = '0;
  logic        host_wr = 1'b0, host_rd = 1'b0, host_word = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        host_irq;
  logic        loc_push = 1'b0;
  logic [15:0] loc_push_data = '0;
  logic        loc_in_full;
  logic        loc_pop = 1'b0;
  logic [15:0] loc_pop_data;
  logic        loc_out_empty;
  logic        loc_mbox_wr = 1'b0;
  logic [7:0]  loc_mbox_wdata = '0;
  logic        loc_mbox_rd = 1'b0;
  logic [7:0]  loc_mbox_rdata;
  logic        loc_irq_arm = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] sb_q[$];
  int out_n = 0;

  always #4 clk = ~clk;

  hbx_host_if #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .word_mode(word_mode),
    .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
    .host_word(host_word), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_irq(host_irq), .loc_push(loc_push), .loc_push_data(loc_push_data),
    .loc_in_full(loc_in_full), .loc_pop(loc_pop), .loc_pop_data(loc_pop_data),
    .loc_out_empty(loc_out_empty), .loc_mbox_wr(loc_mbox_wr),
    .loc_mbox_wdata(loc_mbox_wdata), .loc_mbox_rd(loc_mbox_rd),
    .loc_mbox_rdata(loc_mbox_rdata), .loc_irq_arm(loc_irq_arm)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FIFO-IF FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic hwr(input logic [2:0] a, input logic [15:0] d, input logic w);
    host_addr = a; host_wdata = d; host_word = w; host_wr = 1'b1;
    @(posedge clk); #1 host_wr = 1'b0;
  endtask

  task automatic hrd(input logic [2:0] a, input logic w, output logic [15:0] v);
    host_addr = a; host_word = w; host_rd = 1'b1;
    #1 v = host_rdata;
    @(posedge clk); #1 host_rd = 1'b0;
  endtask

  task automatic chk_stat(input string tag, input logic [7:0] exp);
    logic [15:0] v;
    hrd(3'd2, 1'b0, v);
    check(tag, v, {8'h00, exp});
  endtask

  task automatic lpush(input logic [15:0] d);
    loc_push_data = d; loc_push = 1'b1;
    @(posedge clk); #1 loc_push = 1'b0;
  endtask

  task automatic lmbw(input logic [7:0] d);
    loc_mbox_wdata = d; loc_mbox_wr = 1'b1;
    @(posedge clk); #1 loc_mbox_wr = 1'b0;
  endtask

  task automatic lmbr();
    loc_mbox_rd = 1'b1;
    @(posedge clk); #1 loc_mbox_rd = 1'b0;
  endtask

  task automatic arm();
    loc_irq_arm = 1'b1;
    @(posedge clk); #1 loc_irq_arm = 1'b0;
  endtask

  // Driver: one host push, with the expected entry queued when room remains.
  task automatic host_push(input logic [15:0] d, input logic w, input logic [15:0] exp);
    int cap;
    cap = word_mode ? DEPTH : DEPTH / 2;
    hwr(3'd0, d, w);
    if (out_n < cap) begin
      sb_q.push_back(exp);
      out_n++;
    end
  endtask

  // Monitor: pops the outbound FIFO and compares each entry with the queue.
  task automatic drain(input string tag);
    while (loc_out_empty === 1'b0) begin
      if (sb_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FIFO-IF FAIL %s: extra entry 0x%04h expected none", tag, loc_pop_data);
      end else begin
        check(tag, loc_pop_data, sb_q.pop_front());
      end
      loc_pop = 1'b1;
      @(posedge clk); #1 loc_pop = 1'b0;
    end
    check({tag, " leftover"}, 16'(sb_q.size()), 16'd0);
    sb_q.delete();
    out_n = 0;
  endtask

  initial begin
    #(8 * 200000);
    n_cmp++; n_bad++;
    $display("FIFO-IF FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk_stat("R1 status", 8'h21);
    check("R1 irq", 16'(host_irq), 16'd0);
    hrd(3'd3, 1'b0, v); check("R1 mailbox", v, 16'h0000);

    // R2, R5 byte mode: capacity 8
    for (int i = 0; i < 9; i++) begin
      host_push(16'hFF10 + 16'(i), 1'b0, 16'h0010 + 16'(i));
      if (i == 3) chk_stat("R5 out half byte", 8'h30);
    end
    chk_stat("R2 out full byte", 8'h70);
    drain("R2 byte drain");
    chk_stat("R2 after drain", 8'h21);

    // R3 word mode
    word_mode = 1'b1;
    host_push(16'hBEEF, 1'b1, 16'hBEEF);
    hwr(3'd1, 16'h00A5, 1'b0);
    host_push(16'h003C, 1'b0, 16'hA53C);
    drain("R3 word lanes");
    for (int i = 0; i < 17; i++) begin
      host_push(16'h1000 + 16'(i), 1'b1, 16'h1000 + 16'(i));
      if (i == 7) chk_stat("R3 not full at half", 8'h30);
    end
    chk_stat("R3 out full word", 8'h70);
    drain("R3 word drain");

    // R4 inbound reads
    lpush(16'h1234); lpush(16'hABCD);
    chk_stat("R5 inbound present", 8'h01);
    hrd(3'd0, 1'b1, v); check("R4 word read", v, 16'h1234);
    hrd(3'd0, 1'b0, v); check("R4 byte read", v, 16'h00CD);
    chk_stat("R4 emptied", 8'h21);
    hrd(3'd0, 1'b1, v); check("R4 empty read", v, 16'h0000);
    chk_stat("R4 empty no pop", 8'h21);
    for (int i = 0; i < 17; i++) begin
      lpush(16'h2000 + 16'(i));
      if (i == 7) chk_stat("R5 in half", 8'h09);
    end
    chk_stat("R5 in full", 8'h0B);
    check("R5 loc_in_full", 16'(loc_in_full), 16'd1);

    // R6, R7 mask and enable
    hwr(3'd2, 16'h0020, 1'b0);
    check("R7 irq gated", 16'(host_irq), 16'd0);
    arm();
    check("R6 in full irq", 16'(host_irq), 16'd1);
    hwr(3'd2, 16'h0012, 1'b0);
    check("R6 reserved bits", 16'(host_irq), 16'd0);
    hwr(3'd2, 16'h0001, 1'b0);
    check("R6 out empty irq", 16'(host_irq), 16'd1);
    hwr(3'd2, 16'h0004, 1'b0);
    check("R6 out full off", 16'(host_irq), 16'd0);
    hwr(3'd2, 16'h0008, 1'b0);
    check("R6 in empty off", 16'(host_irq), 16'd0);
    for (int i = 0; i < 16; i++) begin
      hrd(3'd0, 1'b1, v); check("R4 inbound order", v, 16'h2000 + 16'(i));
    end
    check("R6 in empty irq", 16'(host_irq), 16'd1);
    hwr(3'd2, 16'h0040, 1'b0);
    check("R6 in mail off", 16'(host_irq), 16'd0);
    lmbw(8'hFF);
    check("R6 in mail irq", 16'(host_irq), 16'd1);

    // R8, R9, R10 mailboxes
    chk_stat("R5 in mail", 8'h25);
    hrd(3'd3, 1'b0, v); check("R8 inbound 6 bits", v, 16'h00FC);
    chk_stat("R9 inbound cleared", 8'h21);
    check("R9 irq drop", 16'(host_irq), 16'd0);
    hwr(3'd3, 16'h0057, 1'b0);
    chk_stat("R10 out mail set", 8'hA1);
    hrd(3'd3, 1'b0, v); check("R9 select inbound", v, 16'h00FC);
    hwr(3'd2, 16'h0080, 1'b0);
    hrd(3'd3, 1'b0, v); check("R9 select outbound", v, 16'h0054);
    chk_stat("R9 outbound read keeps", 8'hA1);
    check("R8 local view", 16'(loc_mbox_rdata), 16'h0054);
    lmbr();
    chk_stat("R10 consumed", 8'h21);
    hrd(3'd3, 1'b0, v); check("R10 kept", v, 16'h0054);
    lmbw(8'h03);
    hrd(3'd3, 1'b0, v); check("R9 rsel read", v, 16'h0054);
    chk_stat("R9 rsel no clear", 8'h25);

    // R11 soft reset
    hwr(3'd0, 16'h7777, 1'b1);
    lpush(16'h0055);
    hwr(3'd2, 16'h0040, 1'b0);
    check("R11 irq before", 16'(host_irq), 16'd1);
    hrd(3'd7, 1'b0, v); check("R11 read 7 data", v, 16'h0000);
    chk_stat("R11 read 7 no effect", 8'h04);
    hwr(3'd7, 16'h0000, 1'b0);
    chk_stat("R11 cleared", 8'h21);
    check("R11 irq off", 16'(host_irq), 16'd0);
    hrd(3'd3, 1'b0, v); check("R11 mailbox", v, 16'h0000);
    check("R11 local mailbox", 16'(loc_mbox_rdata), 16'h0000);
    check("R11 out empty", 16'(loc_out_empty), 16'd1);
    arm();
    check("R11 mask cleared", 16'(host_irq), 16'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule